// File: doc/BRIEF.md
# Background Flash Streaming Engine

This block copies a linear run of 32-bit words out of flash into a small local FIFO while the processor runs, so that a DMA channel can collect the data without waiting on flash latency. Software loads a word-aligned start address and a word count. The engine then issues one read per free flash cycle until the count runs out. It yields to foreground traffic whenever the shared flash controller reports a pending access.

Each read carries an epoch tag, and the controller returns the tag with the response. When the count is written with zero, the stream stops and the epoch changes. Any response still on its way back then carries a stale tag and is dropped, so the next stream can be programmed at once. A credit rule stops the engine from having more reads in flight than the FIFO has free slots. With the default depth of two, the full and empty flags together give the exact fill level.

Top module: `flash_stream_engine`

## Requirements
- R1: After reset the FIFO is empty (`fifo_empty`=1, `fifo_full`=0), the address and count read as 0, and no flash request is raised.
- R2: The address register stores only bits [ADDR_W-1:2]. The two low bits of a written value are discarded and always read as 0.
- R3: Writing a nonzero count starts streaming. Each request presents the current address on `fl_req_addr`. One cycle later the address has grown by 4 and the count has dropped by 1.
- R4: While the count is 0, no request is issued.
- R5: A request is raised only in a cycle where `fg_busy` is 0.
- R6: A request is raised only while FIFO fill level plus reads in flight is below DEPTH. The FIFO therefore never receives a write while full.
- R7: Accepted responses enter the FIFO in issue order. `fifo_rdata` shows the oldest word. With DEPTH=2, `fifo_full`=1 means two words are stored, and both flags low means one word is stored.
- R8: Writing 0 to the count aborts the stream. The count is 0 on the next cycle, no further request is raised, and a response tagged with the old epoch is never stored. A new stream may be programmed on the following cycle.
- R9: Popping an empty FIFO has no effect. While the FIFO is empty, `fifo_rdata` reads 0.
- R10: No request is raised in a cycle where the address or count register is being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr_we | input | 1 | Write strobe for the start address |
| cfg_addr_wdata | input | ADDR_W | New start address (low two bits ignored) |
| cfg_cnt_we | input | 1 | Write strobe for the word count (zero aborts) |
| cfg_cnt_wdata | input | CNT_W | New word count |
| stream_addr | output | ADDR_W | Address of the next word to fetch |
| stream_cnt | output | CNT_W | Words still to be requested |
| fg_busy | input | 1 | Foreground flash access pending |
| fl_req_valid | output | 1 | Read request, accepted in the same cycle |
| fl_req_addr | output | ADDR_W | Read request address |
| fl_req_tag | output | TAG_W | Epoch tag of the request |
| fl_rsp_valid | input | 1 | Read response strobe |
| fl_rsp_data | input | DATA_W | Read response data |
| fl_rsp_tag | input | TAG_W | Epoch tag echoed with the response |
| fifo_pop | input | 1 | Pop the oldest FIFO word |
| fifo_rdata | output | DATA_W | Oldest FIFO word, 0 when empty |
| fifo_full | output | 1 | FIFO holds DEPTH words |
| fifo_empty | output | 1 | FIFO holds no words |

## Verification
The bench builds the engine with DEPTH=2, TAG_W=1, ADDR_W=DATA_W=32 and CNT_W=8. A flash model with a fixed three-cycle response latency is attached. With two slots and a three-cycle round trip, the credit limit is the only thing that stops a third request, so a missing credit check shows up as an overflow. The one-bit epoch is enough to prove that a stale response is dropped, because a new stream is programmed while the aborted read is still on its way back.

// File: rtl/stream_pkg.sv
`timescale 1ns/1ps
package stream_pkg;
   // byte offset between consecutive words
   localparam int unsigned WORD_BYTES = 4;
   localparam int unsigned WORD_SHIFT = 2;

   // width needed to hold values 0..n
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

   // width of an index into n entries
   function automatic int unsigned idx_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/stream_ctl.sv
`timescale 1ns/1ps
module stream_ctl #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned CNT_W  = 22
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_we,
   input  logic [ADDR_W-1:0] addr_wdata,
   input  logic              cnt_we,
   input  logic [CNT_W-1:0]  cnt_wdata,
   input  logic              issue,
   output logic [ADDR_W-1:0] addr_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              abort
);
   import stream_pkg::*;

   localparam int unsigned HI_W = ADDR_W - WORD_SHIFT;

   logic [HI_W-1:0] word_q;

   assign abort  = cnt_we && (cnt_wdata == '0);
   assign addr_q = {word_q, {WORD_SHIFT{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (addr_we) begin
         word_q <= addr_wdata[ADDR_W-1:WORD_SHIFT];
      end else if (issue) begin
         word_q <= word_q + HI_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_we) begin
         cnt_q <= cnt_wdata;
      end else if (issue) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end
endmodule

// File: rtl/stream_credit.sv
`timescale 1ns/1ps
module stream_credit #(
   parameter int unsigned DEPTH = 2,
   parameter int unsigned TAG_W = 1,
   parameter int unsigned LVL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             abort,
   input  logic             issue,
   input  logic             rsp_valid,
   input  logic [TAG_W-1:0] rsp_tag,
   input  logic [LVL_W-1:0] level,
   output logic [TAG_W-1:0] epoch,
   output logic             push,
   output logic             room
);
   logic [LVL_W-1:0] inflight_q;
   logic [LVL_W:0]   committed;

   // a matching response is stored unless the stream dies this cycle
   assign push      = rsp_valid && (rsp_tag == epoch) && !abort;
   assign committed = {1'b0, level} + {1'b0, inflight_q};
   assign room      = committed < (LVL_W + 1)'(DEPTH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inflight_q <= '0;
         epoch      <= '0;
      end else if (abort) begin
         inflight_q <= '0;
         epoch      <= epoch + TAG_W'(1);
      end else begin
         case ({issue, push})
            2'b10:   inflight_q <= inflight_q + LVL_W'(1);
            2'b01:   inflight_q <= inflight_q - LVL_W'(1);
            default: inflight_q <= inflight_q;
         endcase
      end
   end
endmodule

// File: rtl/stream_fifo.sv
`timescale 1ns/1ps
module stream_fifo #(
   parameter int unsigned DEPTH  = 2,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LVL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pop,
   output logic [DATA_W-1:0] rdata,
   output logic [LVL_W-1:0]  level,
   output logic              full,
   output logic              empty
);
   import stream_pkg::*;

   localparam int unsigned IDX_W = idx_width(DEPTH);
   localparam bit          POW2  = (DEPTH == (1 << IDX_W));

   logic [DATA_W-1:0] mem [DEPTH];
   logic [IDX_W-1:0]  wr_q, rd_q, wr_nx, rd_nx;
   logic              do_pop;

   assign empty  = (level == '0);
   assign full   = (level == LVL_W'(DEPTH));
   assign do_pop = pop && !empty;
   assign rdata  = empty ? '0 : mem[rd_q];

   generate
      if (POW2) begin : g_wrap_free
         assign wr_nx = wr_q + IDX_W'(1);
         assign rd_nx = rd_q + IDX_W'(1);
      end else begin : g_wrap_cmp
         assign wr_nx = (wr_q == IDX_W'(DEPTH - 1)) ? '0 : wr_q + IDX_W'(1);
         assign rd_nx = (rd_q == IDX_W'(DEPTH - 1)) ? '0 : rd_q + IDX_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wr_q] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         level <= '0;
      end else begin
         if (push)   wr_q <= wr_nx;
         if (do_pop) rd_q <= rd_nx;
         case ({push, do_pop})
            2'b10:   level <= level + LVL_W'(1);
            2'b01:   level <= level - LVL_W'(1);
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/flash_stream_engine.sv
`timescale 1ns/1ps
module flash_stream_engine #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 22,
   parameter int unsigned DEPTH  = 2,
   parameter int unsigned TAG_W  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_addr_we,
   input  logic [ADDR_W-1:0] cfg_addr_wdata,
   input  logic              cfg_cnt_we,
   input  logic [CNT_W-1:0]  cfg_cnt_wdata,
   output logic [ADDR_W-1:0] stream_addr,
   output logic [CNT_W-1:0]  stream_cnt,
   input  logic              fg_busy,
   output logic              fl_req_valid,
   output logic [ADDR_W-1:0] fl_req_addr,
   output logic [TAG_W-1:0]  fl_req_tag,
   input  logic              fl_rsp_valid,
   input  logic [DATA_W-1:0] fl_rsp_data,
   input  logic [TAG_W-1:0]  fl_rsp_tag,
   input  logic              fifo_pop,
   output logic [DATA_W-1:0] fifo_rdata,
   output logic              fifo_full,
   output logic              fifo_empty
);
   import stream_pkg::*;

   localparam int unsigned LVL_W = cnt_width(DEPTH);

   generate
      if (DEPTH < 2)             begin : g_bad_depth $error("DEPTH must be 2 or more"); end
      if (ADDR_W <= WORD_SHIFT)  begin : g_bad_addr  $error("ADDR_W too small"); end
      if (CNT_W < 1)             begin : g_bad_cnt   $error("CNT_W must be positive"); end
      if (TAG_W < 1)             begin : g_bad_tag   $error("TAG_W must be positive"); end
   endgenerate

   logic             issue, abort, push, room;
   logic [LVL_W-1:0] level;
   logic [TAG_W-1:0] epoch;

   // config writes take the cycle; foreground traffic has priority
   assign issue = (stream_cnt != '0) && !fg_busy && room
                  && !cfg_addr_we && !cfg_cnt_we;

   assign fl_req_valid = issue;
   assign fl_req_addr  = stream_addr;
   assign fl_req_tag   = epoch;

   stream_ctl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_we    (cfg_addr_we),
      .addr_wdata (cfg_addr_wdata),
      .cnt_we     (cfg_cnt_we),
      .cnt_wdata  (cfg_cnt_wdata),
      .issue      (issue),
      .addr_q     (stream_addr),
      .cnt_q      (stream_cnt),
      .abort      (abort)
   );

   stream_credit #(.DEPTH(DEPTH), .TAG_W(TAG_W), .LVL_W(LVL_W)) u_credit (
      .clk       (clk),
      .rst_n     (rst_n),
      .abort     (abort),
      .issue     (issue),
      .rsp_valid (fl_rsp_valid),
      .rsp_tag   (fl_rsp_tag),
      .level     (level),
      .epoch     (epoch),
      .push      (push),
      .room      (room)
   );

   stream_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .wdata (fl_rsp_data),
      .pop   (fifo_pop),
      .rdata (fifo_rdata),
      .level (level),
      .full  (fifo_full),
      .empty (fifo_empty)
   );
endmodule

// File: rtl/stream_chk.sv
`timescale 1ns/1ps
module stream_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 22
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_addr_we,
   input logic              cfg_cnt_we,
   input logic [CNT_W-1:0]  cfg_cnt_wdata,
   input logic [ADDR_W-1:0] stream_addr,
   input logic [CNT_W-1:0]  stream_cnt,
   input logic              fg_busy,
   input logic              fl_req_valid,
   input logic              fifo_pop,
   input logic [DATA_W-1:0] fifo_rdata,
   input logic              fifo_full,
   input logic              fifo_empty,
   input logic              push
);
   // R2
   addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stream_addr[1:0] == 2'b00);

   // R3
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req_valid |=> stream_addr == $past(stream_addr) + ADDR_W'(4));

   // R3
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req_valid |=> stream_cnt == $past(stream_cnt) - CNT_W'(1));

   // R4
   zero_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stream_cnt == '0) |-> !fl_req_valid);

   // R5
   fg_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req_valid |-> !fg_busy);

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |-> !push);

   // R7
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_full && fifo_empty));

   // R8
   abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_cnt_we && cfg_cnt_wdata == '0) |-> !push);

   // R8
   abort_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_cnt_we && cfg_cnt_wdata == '0) |=> (stream_cnt == '0 && !fl_req_valid));

   // R9
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_empty && fifo_pop && !push) |=> fifo_empty);

   // R9
   empty_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_empty |-> fifo_rdata == '0);

   // R10
   cfg_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr_we || cfg_cnt_we) |-> !fl_req_valid);
endmodule

bind flash_stream_engine stream_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_addr_we   (cfg_addr_we),
   .cfg_cnt_we    (cfg_cnt_we),
   .cfg_cnt_wdata (cfg_cnt_wdata),
   .stream_addr   (stream_addr),
   .stream_cnt    (stream_cnt),
   .fg_busy       (fg_busy),
   .fl_req_valid  (fl_req_valid),
   .fifo_pop      (fifo_pop),
   .fifo_rdata    (fifo_rdata),
   .fifo_full     (fifo_full),
   .fifo_empty    (fifo_empty),
   .push          (push)
);

// File: tb/sim_flash_stream_engine.sv
`timescale 1ns/1ps
module sim_flash_stream_engine;
   localparam int AW = 32, DW = 32, CW = 8, DEPTH = 2, TW = 1, LAT = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_addr_we = 1'b0;
   logic [AW-1:0] cfg_addr_wdata = '0;
   logic          cfg_cnt_we = 1'b0;
   logic [CW-1:0] cfg_cnt_wdata = '0;
   logic [AW-1:0] stream_addr;
   logic [CW-1:0] stream_cnt;
   logic          fg_busy = 1'b0;
   logic          fl_req_valid;
   logic [AW-1:0] fl_req_addr;
   logic [TW-1:0] fl_req_tag;
   logic          fl_rsp_valid;
   logic [DW-1:0] fl_rsp_data;
   logic [TW-1:0] fl_rsp_tag;
   logic          fifo_pop = 1'b0;
   logic [DW-1:0] fifo_rdata;
   logic          fifo_full, fifo_empty;

   int n_chk = 0, n_err = 0, req_cnt = 0, viol_fg = 0, viol_cfg = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   flash_stream_engine #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .DEPTH(DEPTH), .TAG_W(TW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_addr_we(cfg_addr_we), .cfg_addr_wdata(cfg_addr_wdata),
      .cfg_cnt_we(cfg_cnt_we), .cfg_cnt_wdata(cfg_cnt_wdata),
      .stream_addr(stream_addr), .stream_cnt(stream_cnt),
      .fg_busy(fg_busy),
      .fl_req_valid(fl_req_valid), .fl_req_addr(fl_req_addr), .fl_req_tag(fl_req_tag),
      .fl_rsp_valid(fl_rsp_valid), .fl_rsp_data(fl_rsp_data), .fl_rsp_tag(fl_rsp_tag),
      .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata),
      .fifo_full(fifo_full), .fifo_empty(fifo_empty)
   );

   // flash content model: word at address a
   function automatic logic [DW-1:0] fdat(input logic [AW-1:0] a);
      return ~a ^ 32'h3C00_0000;
   endfunction

   // fixed-latency flash model
   logic [LAT-1:0] st_v;
   logic [AW-1:0]  st_a [0:LAT-1];
   logic [TW-1:0]  st_t [0:LAT-1];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_v <= '0;
         for (int i = 0; i < LAT; i++) begin
            st_a[i] <= '0;
            st_t[i] <= '0;
         end
      end else begin
         st_v    <= {st_v[LAT-2:0], fl_req_valid};
         st_a[0] <= fl_req_addr;
         st_t[0] <= fl_req_tag;
         for (int i = 1; i < LAT; i++) begin
            st_a[i] <= st_a[i-1];
            st_t[i] <= st_t[i-1];
         end
         if (fl_req_valid) req_cnt <= req_cnt + 1;
         if (fl_req_valid && fg_busy) viol_fg <= viol_fg + 1;
         if (fl_req_valid && (cfg_addr_we || cfg_cnt_we)) viol_cfg <= viol_cfg + 1;
      end
   end

   assign fl_rsp_valid = st_v[LAT-1];
   assign fl_rsp_data  = fdat(st_a[LAT-1]);
   assign fl_rsp_tag   = st_t[LAT-1];

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic wr_addr(input logic [AW-1:0] a);
      @(negedge clk); cfg_addr_we = 1'b1; cfg_addr_wdata = a;
      @(negedge clk); cfg_addr_we = 1'b0;
   endtask

   task automatic wr_cnt(input logic [CW-1:0] c);
      @(negedge clk); cfg_cnt_we = 1'b1; cfg_cnt_wdata = c;
      @(negedge clk); cfg_cnt_we = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // pop n words and compare against the flash image starting at base
   task automatic drain(input int n, input logic [AW-1:0] base, input string rq);
      int got = 0;
      int guard = 0;
      while (got < n && guard < 500) begin
         @(negedge clk);
         guard++;
         if (!fifo_empty) begin
            chk(fifo_rdata == fdat(base + AW'(4 * got)), rq, fifo_rdata, fdat(base + AW'(4 * got)));
            got++;
            fifo_pop = 1'b1;
         end else begin
            fifo_pop = 1'b0;
         end
      end
      @(negedge clk); fifo_pop = 1'b0;
      chk(got == n, {rq, " word count"}, got, n);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(fifo_empty == 1'b1, "R1 empty", fifo_empty, 1);
      chk(fifo_full == 1'b0, "R1 full", fifo_full, 0);
      chk(stream_cnt == '0, "R1 count", stream_cnt, 0);
      chk(stream_addr == '0, "R1 addr", stream_addr, 0);
      chk(fl_req_valid == 1'b0, "R1 request", fl_req_valid, 0);
   endtask

   task automatic t_align();
      wr_addr(32'h0000_1003);
      chk(stream_addr == 32'h0000_1000, "R2 low bits dropped", stream_addr, 32'h1000);
      wr_addr(32'hFFFF_FFFE);
      chk(stream_addr == 32'hFFFF_FFFC, "R2 high addr", stream_addr, 32'hFFFF_FFFC);
   endtask

   task automatic t_stream();
      int r0;
      wr_addr(32'h0000_0100);
      r0 = req_cnt;
      wr_cnt(8'd5);
      idle(20);
      // R6: two slots, nothing popped, so exactly two requests
      chk(req_cnt - r0 == 2, "R6 credit limit", req_cnt - r0, 2);
      chk(fifo_full == 1'b1 && fifo_empty == 1'b0, "R7 full level", {fifo_full, fifo_empty}, 2'b10);
      chk(stream_cnt == 8'd3, "R3 count step", stream_cnt, 3);
      chk(stream_addr == 32'h0000_0108, "R3 addr step", stream_addr, 32'h108);
      // R7: one pop leaves exactly one word (both flags low)
      @(negedge clk); fifo_pop = 1'b1;
      @(negedge clk); fifo_pop = 1'b0;
      chk(!fifo_full && !fifo_empty, "R7 one word", {fifo_full, fifo_empty}, 2'b00);
      drain(4, 32'h0000_0104, "R7 order");
      chk(stream_cnt == '0, "R3 count done", stream_cnt, 0);
      r0 = req_cnt;
      idle(20);
      chk(req_cnt == r0, "R4 halt at zero", req_cnt - r0, 0);
      chk(fifo_empty == 1'b1, "R4 no extra words", fifo_empty, 1);
   endtask

   task automatic t_fg();
      int r0;
      fg_busy = 1'b1;
      wr_addr(32'h0000_0200);
      r0 = req_cnt;
      wr_cnt(8'd3);
      idle(30);
      chk(req_cnt == r0, "R5 yield to foreground", req_cnt - r0, 0);
      chk(stream_cnt == 8'd3, "R5 count held", stream_cnt, 3);
      @(negedge clk); fg_busy = 1'b0;
      drain(3, 32'h0000_0200, "R5 resume");
   endtask

   task automatic t_abort();
      int r0;
      int guard = 0;
      wr_addr(32'h0000_0400);
      r0 = req_cnt;
      wr_cnt(8'd10);
      while (req_cnt == r0 && guard < 50) begin
         @(negedge clk);
         guard++;
      end
      // first read is in flight; kill the stream now
      cfg_cnt_we = 1'b1; cfg_cnt_wdata = '0;
      @(negedge clk); cfg_cnt_we = 1'b0;
      chk(stream_cnt == '0, "R8 count cleared", stream_cnt, 0);
      chk(req_cnt - r0 == 1, "R8 halted at once", req_cnt - r0, 1);
      // restart immediately while the stale read is returning
      wr_addr(32'h0000_0800);
      wr_cnt(8'd2);
      drain(2, 32'h0000_0800, "R8 stale dropped");
      idle(10);
      chk(fifo_empty == 1'b1, "R8 nothing left", fifo_empty, 1);
   endtask

   task automatic t_empty_pop();
      @(negedge clk);
      chk(fifo_rdata == '0, "R9 empty data", fifo_rdata, 0);
      fifo_pop = 1'b1;
      @(negedge clk); fifo_pop = 1'b0;
      chk(fifo_empty == 1'b1 && fifo_full == 1'b0, "R9 pop ignored", {fifo_full, fifo_empty}, 2'b01);
      wr_addr(32'h0000_0C00);
      wr_cnt(8'd1);
      drain(1, 32'h0000_0C00, "R9 after empty pop");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_align();
      t_stream();
      t_fg();
      t_abort();
      t_empty_pop();
      chk(viol_fg == 0, "R5 no request while busy", viol_fg, 0);
      chk(viol_cfg == 0, "R10 no request on config write", viol_cfg, 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule